// File: doc/BRIEF.md
# Chained DMA descriptor loader

This block is the front end of one DMA channel. Software sets a chaining enable bit in a control register and then writes the memory address of a four-word descriptor into the chain-pointer register. The block then reads that descriptor from memory without further help. It copies the descriptor's fields into the channel's working registers: the next-descriptor pointer, the word count, the signed step, and the start address. It then moves one word per granted memory access until the count reaches zero.

When a sequence ends, the chain pointer decides what happens next. A nonzero pointer makes the block fetch the next descriptor and run it. A pointer of zero ends the chain with a one-cycle done pulse. A descriptor that points to itself repeats the same transfer until software clears the enable bit. Software may rewrite the chain pointer while a sequence is running, and the new value is used at the next descriptor fetch.

Descriptor reads and data moves share one memory port with a request/grant handshake. A flag on that port tells the two kinds of access apart. The data word of a transfer appears on the read-data input in its granted cycle and is consumed outside this block.

Top module: `dmac_chain_loader`

## Requirements
- R1: After reset the channel is idle: `busy`, `mem_req` and `chain_done` are 0, chaining is disabled and the chain pointer is zero.
- R2: A write to the chain pointer (`cfg_sel`=1) starts the chain only under three conditions: the written value is nonzero, chaining is enabled (control bit 0 = 1), and the channel is idle. In the cycle after such a write, `mem_req`=1, `mem_is_xfer`=0 and `mem_addr` equals the written value.
- R3: A descriptor is read as four words at ascending addresses. The word at offset 0 is the next pointer, offset 1 the count, offset 2 the modify, and offset 3 the index. Each word is read in one granted access, and an ungranted request holds its address and kind.
- R4: Each granted transfer (`mem_is_xfer`=1) reads address index. The index then becomes index + modify modulo 2^AW, so the modify acts as two's complement, and the count drops by one. A sequence makes exactly count transfers.
- R5: Descriptor reads and transfers never overlap. A sequence's transfers begin only after all four of its descriptor words are granted.
- R6: When a sequence ends with chaining enabled and a nonzero chain pointer, the block fetches the descriptor at the chain pointer and runs it, with no software action.
- R7: When a sequence ends and the chain pointer is zero, `chain_done` is high for exactly one cycle. The channel then goes idle with no further memory request.
- R8: A descriptor whose next pointer equals its own address repeats its sequence for as long as chaining stays enabled.
- R9: A chain-pointer write during a running chain does not restart it. The written value replaces the loaded next pointer and selects the next descriptor fetched.
- R10: A descriptor with a count of zero moves no data, and the block proceeds straight to the chain decision.
- R11: A control write alone never starts a fetch. A chain-pointer write of zero, or any chain-pointer write while chaining is disabled, leaves the channel idle.
- R12: Clearing the chaining enable during a running chain lets the current sequence finish. The block then raises `chain_done` and goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 control (bit 0 = chaining enable), 1 chain pointer |
| cfg_wdata | input | AW | Register write data |
| mem_req | output | 1 | Memory access request |
| mem_addr | output | AW | Memory word address |
| mem_is_xfer | output | 1 | 1 = data transfer, 0 = descriptor read |
| mem_gnt | input | 1 | Grant; the access completes in a cycle with `mem_req` and `mem_gnt` high |
| mem_rdata | input | AW | Read data of the granted access |
| busy | output | 1 | Channel is fetching or transferring |
| chain_done | output | 1 | One-cycle pulse when a chain ends |

## Verification
The bench builds the block with AW=8, so the whole 256-word address space is modelled as a bench array. With that width, index wrap-around under both positive and negative modify values occurs within a few transfers. Descriptors can also be placed at random slots across memory, and their random 8-bit modify values cover every step size. Random grant stalls exercise address holding, and a bench-side chain walk predicts the full ordered access trace of each run.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RUN   = 2'd2
  } dmac_state_e;

  // descriptor word offsets (fetch order)
  localparam logic [1:0] OFS_NEXT   = 2'd0;
  localparam logic [1:0] OFS_COUNT  = 2'd1;
  localparam logic [1:0] OFS_MODIFY = 2'd2;
  localparam logic [1:0] OFS_INDEX  = 2'd3;

  // register select codes
  localparam logic SEL_CTRL  = 1'b0;
  localparam logic SEL_CHPTR = 1'b1;

endpackage

// File: rtl/dmac_cfg_regs.sv
module dmac_cfg_regs
  import dmac_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  input  logic          idle,
  input  logic          desc_next_we,
  input  logic [AW-1:0] desc_next,
  output logic          chain_en,
  output logic [AW-1:0] chptr,
  output logic          start_evt
);

  logic wr_ctrl;
  logic wr_ptr;

  assign wr_ctrl = cfg_we && (cfg_sel == SEL_CTRL);
  assign wr_ptr  = cfg_we && (cfg_sel == SEL_CHPTR);

  // a software write of the pointer wins over a descriptor load in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_en <= 1'b0;
      chptr    <= '0;
    end else begin
      if (wr_ctrl) chain_en <= cfg_wdata[0];
      if (wr_ptr)            chptr <= cfg_wdata;
      else if (desc_next_we) chptr <= desc_next;
    end
  end

  assign start_evt = wr_ptr && chain_en && idle && (cfg_wdata != '0);

endmodule

// File: rtl/dmac_desc_fetch.sv
module dmac_desc_fetch
  import dmac_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          begin_fetch,
  input  logic [AW-1:0] begin_addr,
  input  logic          active,
  input  logic          gnt,
  output logic [AW-1:0] fetch_addr,
  output logic [1:0]    word_idx,
  output logic          word_last
);

  logic [AW-1:0] base_q;
  logic [1:0]    widx_q;

  function automatic logic [AW-1:0] desc_word_addr(input logic [AW-1:0] base,
                                                   input logic [1:0]    ofs);
    return base + AW'(ofs);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      widx_q <= '0;
    end else if (begin_fetch) begin
      base_q <= begin_addr;
      widx_q <= OFS_NEXT;
    end else if (active && gnt) begin
      widx_q <= widx_q + 2'd1;
    end
  end

  assign fetch_addr = desc_word_addr(base_q, widx_q);
  assign word_idx   = widx_q;
  assign word_last  = (widx_q == OFS_INDEX);

endmodule

// File: rtl/dmac_xfer_engine.sv
module dmac_xfer_engine
  import dmac_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_we,
  input  logic [1:0]    load_sel,
  input  logic [AW-1:0] load_word,
  input  logic          step,
  output logic [AW-1:0] index,
  output logic [AW-1:0] modify,
  output logic [AW-1:0] count,
  output logic          count_zero
);

  function automatic logic [AW-1:0] next_index(input logic [AW-1:0] idx,
                                               input logic [AW-1:0] mod);
    return idx + mod;
  endfunction

  function automatic logic [AW-1:0] next_count(input logic [AW-1:0] c);
    return c - AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index  <= '0;
      modify <= '0;
      count  <= '0;
    end else if (load_we) begin
      case (load_sel)
        OFS_COUNT:  count  <= load_word;
        OFS_MODIFY: modify <= load_word;
        OFS_INDEX:  index  <= load_word;
        default:    ;
      endcase
    end else if (step) begin
      index <= next_index(index, modify);
      count <= next_count(count);
    end
  end

  assign count_zero = (count == '0);

endmodule

// File: rtl/dmac_chain_loader.sv
module dmac_chain_loader
  import dmac_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic          cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_is_xfer,
  input  logic          mem_gnt,
  input  logic [AW-1:0] mem_rdata,
  output logic          busy,
  output logic          chain_done
);

  dmac_state_e   state_q, state_d;

  // named internal events
  logic          fetch_active;
  logic          run_active;
  logic          seq_end;
  logic          chain_go;
  logic          begin_fetch;
  logic [AW-1:0] begin_addr;
  logic          desc_take;
  logic          desc_next_we;
  logic          xfer_step;

  logic          chain_en;
  logic [AW-1:0] chptr;
  logic          start_evt;
  logic [AW-1:0] fetch_addr;
  logic [1:0]    fetch_widx;
  logic          word_last;
  logic [AW-1:0] xfer_index;
  logic [AW-1:0] xfer_modify;
  logic [AW-1:0] xfer_count;
  logic          count_zero;

  assign fetch_active = (state_q == ST_FETCH);
  assign run_active   = (state_q == ST_RUN);
  assign seq_end      = run_active && count_zero;
  assign chain_go     = seq_end && chain_en && (chptr != '0);
  assign begin_fetch  = start_evt || chain_go;
  assign begin_addr   = start_evt ? cfg_wdata : chptr;
  assign desc_take    = fetch_active && mem_gnt;
  assign desc_next_we = desc_take && (fetch_widx == OFS_NEXT);
  assign xfer_step    = run_active && !count_zero && mem_gnt;

  dmac_cfg_regs #(.AW(AW)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_sel      (cfg_sel),
    .cfg_wdata    (cfg_wdata),
    .idle         (state_q == ST_IDLE),
    .desc_next_we (desc_next_we),
    .desc_next    (mem_rdata),
    .chain_en     (chain_en),
    .chptr        (chptr),
    .start_evt    (start_evt)
  );

  dmac_desc_fetch #(.AW(AW)) u_fetch (
    .clk         (clk),
    .rst_n       (rst_n),
    .begin_fetch (begin_fetch),
    .begin_addr  (begin_addr),
    .active      (fetch_active),
    .gnt         (mem_gnt),
    .fetch_addr  (fetch_addr),
    .word_idx    (fetch_widx),
    .word_last   (word_last)
  );

  dmac_xfer_engine #(.AW(AW)) u_xfer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_we    (desc_take && (fetch_widx != OFS_NEXT)),
    .load_sel   (fetch_widx),
    .load_word  (mem_rdata),
    .step       (xfer_step),
    .index      (xfer_index),
    .modify     (xfer_modify),
    .count      (xfer_count),
    .count_zero (count_zero)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (start_evt) state_d = ST_FETCH;
      ST_FETCH: if (mem_gnt && word_last) state_d = ST_RUN;
      ST_RUN:   if (seq_end) state_d = chain_go ? ST_FETCH : ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign mem_req     = fetch_active || (run_active && !count_zero);
  assign mem_is_xfer = run_active;
  assign mem_addr    = fetch_active ? fetch_addr : xfer_index;
  assign busy        = (state_q != ST_IDLE);
  assign chain_done  = seq_end && !chain_go;

endmodule

// File: rtl/dmac_chain_sva.sv
module dmac_chain_sva #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_is_xfer,
  input logic          mem_gnt,
  input logic          busy,
  input logic          chain_done,
  input logic          start_evt,
  input logic [AW-1:0] cfg_wdata,
  input logic [1:0]    word_idx,
  input logic [AW-1:0] cnt_q,
  input logic [AW-1:0] mod_q
);

  logic [AW-1:0] addr_plus_one;
  logic [AW-1:0] addr_plus_mod;
  assign addr_plus_one = mem_addr + AW'(1);
  assign addr_plus_mod = mem_addr + mod_q;

  assert_start_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> mem_req && !mem_is_xfer && (mem_addr == $past(cfg_wdata)));

  assert_hold_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_is_xfer));

  assert_desc_ascend_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt && !mem_is_xfer && (word_idx != 2'd3)
      |=> mem_req && !mem_is_xfer && (mem_addr == $past(addr_plus_one)));

  assert_xfer_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt && mem_is_xfer && (cnt_q > AW'(1))
      |=> mem_req && mem_is_xfer && (mem_addr == $past(addr_plus_mod)));

  assert_run_after_desc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_gnt && !mem_is_xfer && (word_idx == 2'd3) |=> mem_is_xfer);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |=> !busy && !mem_req && !chain_done);

endmodule

bind dmac_chain_loader dmac_chain_sva #(.AW(AW)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_is_xfer (mem_is_xfer),
  .mem_gnt     (mem_gnt),
  .busy        (busy),
  .chain_done  (chain_done),
  .start_evt   (start_evt),
  .cfg_wdata   (cfg_wdata),
  .word_idx    (fetch_widx),
  .cnt_q       (xfer_count),
  .mod_q       (xfer_modify)
);

// File: tb/tb_dmac_chain_loader.sv
module tb_dmac_chain_loader;

  localparam int AW    = 8;
  localparam int MEMSZ = 1 << AW;
  localparam int LOGSZ = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic          cfg_sel = 1'b0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          mem_req, mem_is_xfer, busy, chain_done;
  logic          mem_gnt;
  logic [AW-1:0] mem_addr, mem_rdata;
  logic [AW-1:0] mem [0:MEMSZ-1];

  always #10 clk = ~clk;

  assign mem_rdata = mem[mem_addr];

  dmac_chain_loader #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_is_xfer(mem_is_xfer), .mem_gnt(mem_gnt),
    .mem_rdata(mem_rdata), .busy(busy), .chain_done(chain_done)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [AW:0] rec   [0:LOGSZ-1];
  logic [AW:0] exp_q [0:LOGSZ-1];
  int rec_n = 0;
  int exp_n = 0;
  int done_cnt = 0;
  bit done_prev = 1'b0;
  bit done_wide = 1'b0;

  // grant driver and access recorder: the access taken at the next edge is logged now
  always @(negedge clk) begin
    bit g;
    g = (($urandom % 4) != 0);
    mem_gnt = g;
    if (rst_n && mem_req && g && rec_n < LOGSZ) begin
      rec[rec_n] = {mem_is_xfer, mem_addr};
      rec_n++;
    end
    if (rst_n) begin
      if (chain_done) begin
        done_cnt++;
        if (done_prev) done_wide = 1'b1;
      end
      done_prev = chain_done;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input bit x, input logic [AW-1:0] a);
    if (exp_n < LOGSZ) begin
      exp_q[exp_n] = {x, a};
      exp_n++;
    end
  endtask

  // expected accesses of one descriptor: four reads, then count steps of index
  task automatic push_desc(input logic [AW-1:0] d, output logic [AW-1:0] nxt);
    logic [AW-1:0] cnt, stp, idx;
    for (int k = 0; k < 4; k++) push(1'b0, d + AW'(k));
    nxt = mem[d];
    cnt = mem[d + AW'(1)];
    stp = mem[d + AW'(2)];
    idx = mem[d + AW'(3)];
    for (int i = 0; i < int'(cnt); i++) begin
      push(1'b1, idx);
      idx = idx + stp;
    end
  endtask

  task automatic walk_chain(input logic [AW-1:0] head);
    logic [AW-1:0] d, nxt;
    d = head;
    for (int s = 0; s < 16; s++) begin
      push_desc(d, nxt);
      if (nxt == '0) break;
      d = nxt;
    end
  endtask

  task automatic set_desc(input logic [AW-1:0] a, input logic [AW-1:0] nxt,
                          input logic [AW-1:0] cnt, input logic [AW-1:0] stp,
                          input logic [AW-1:0] idx);
    mem[a] = nxt;
    mem[a + AW'(1)] = cnt;
    mem[a + AW'(2)] = stp;
    mem[a + AW'(3)] = idx;
  endtask

  task automatic clear_log();
    rec_n = 0;
    exp_n = 0;
    done_cnt = 0;
    done_wide = 1'b0;
  endtask

  task automatic cfg_write(input logic sel, input logic [AW-1:0] data);
    @(negedge clk);
    cfg_sel = sel;
    cfg_wdata = data;
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(!busy && !mem_req, req, "channel idle after chain", busy, 0);
  endtask

  task automatic cmp_trace(input string req);
    int bad;
    bad = -1;
    for (int i = 0; i < rec_n && i < exp_n; i++) begin
      if (rec[i] !== exp_q[i]) begin
        bad = i;
        break;
      end
    end
    if (rec_n != exp_n)  chk(1'b0, req, "access trace length", rec_n, exp_n);
    else if (bad >= 0)   chk(1'b0, req, "access trace entry {xfer,addr}",
                             int'(rec[bad]), int'(exp_q[bad]));
    else                 chk(1'b1, req, "access trace", rec_n, exp_n);
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog", "run did not finish", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [AW-1:0] nxt;
    logic [AW-1:0] slot [0:3];
    int plen, nd, r;
    bit ok;
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < MEMSZ; i++) mem[i] = AW'($urandom);

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!busy, "R1", "busy in reset", busy, 0);
    chk(!mem_req, "R1", "mem_req in reset", mem_req, 0);
    chk(!chain_done, "R1", "chain_done in reset", chain_done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_req, "R1", "idle after reset release", busy, 0);

    // R11: writes that must not start the channel
    clear_log();
    cfg_write(1'b0, 8'h01);
    cfg_write(1'b1, 8'h00);
    repeat (5) @(negedge clk);
    chk(rec_n == 0 && !busy, "R11", "zero pointer write started", rec_n, 0);
    cfg_write(1'b0, 8'h00);
    cfg_write(1'b1, 8'h40);
    repeat (5) @(negedge clk);
    chk(rec_n == 0 && !busy, "R11", "pointer write with chaining off started", rec_n, 0);
    cfg_write(1'b0, 8'h01);
    repeat (5) @(negedge clk);
    chk(rec_n == 0 && !busy, "R11", "control write started", rec_n, 0);

    // R2 R3 R4 R5 R6 R7: three-descriptor chain with negative step and wrap
    set_desc(8'h10, 8'h20, 8'd3, 8'hFE, 8'h01);
    set_desc(8'h20, 8'h30, 8'd1, 8'h05, 8'h80);
    set_desc(8'h30, 8'h00, 8'd4, 8'h01, 8'hFE);
    clear_log();
    walk_chain(8'h10);
    cfg_write(1'b1, 8'h10);
    chk(mem_req && !mem_is_xfer && mem_addr == 8'h10, "R2", "first descriptor read address",
        int'(mem_addr), 16);
    wait_idle("R7");
    cmp_trace("R3 R4 R5 R6");
    chk(done_cnt == 1 && !done_wide, "R7", "chain_done pulses", done_cnt, 1);

    // R10: zero-count descriptor in the middle
    set_desc(8'h48, 8'h58, 8'd2, 8'h01, 8'h90);
    set_desc(8'h58, 8'h68, 8'd0, 8'h07, 8'h33);
    set_desc(8'h68, 8'h00, 8'd1, 8'h00, 8'hA0);
    clear_log();
    walk_chain(8'h48);
    cfg_write(1'b1, 8'h48);
    wait_idle("R10");
    cmp_trace("R10");
    chk(done_cnt == 1, "R10", "chain_done count", done_cnt, 1);

    // R8 R12: self-linked descriptor, stopped by clearing the enable
    set_desc(8'h70, 8'h70, 8'd2, 8'h03, 8'hC0);
    clear_log();
    push_desc(8'h70, nxt);
    plen = exp_n;
    cfg_write(1'b1, 8'h70);
    for (int i = 0; i < 2000 && rec_n < 3 * plen; i++) @(negedge clk);
    cfg_write(1'b0, 8'h00);
    wait_idle("R12");
    ok = (rec_n % plen == 0) && (rec_n >= 3 * plen);
    for (int i = 0; i < rec_n; i++) if (rec[i] !== exp_q[i % plen]) ok = 1'b0;
    chk(ok, "R8", "repeated sequence trace, length", rec_n, 3 * plen);
    chk(done_cnt == 1, "R12", "chain_done after enable cleared", done_cnt, 1);
    cfg_write(1'b0, 8'h01);

    // R9: pointer rewritten while running
    set_desc(8'h80, 8'h90, 8'd6, 8'h01, 8'h00);
    set_desc(8'h90, 8'h00, 8'd2, 8'h01, 8'h10);
    set_desc(8'hA0, 8'h00, 8'd3, 8'h02, 8'h20);
    clear_log();
    push_desc(8'h80, nxt);
    push_desc(8'hA0, nxt);
    cfg_write(1'b1, 8'h80);
    for (int i = 0; i < 2000 && rec_n < 6; i++) @(negedge clk);
    cfg_write(1'b1, 8'hA0);
    wait_idle("R9");
    cmp_trace("R9");

    // R6 R4 R10: random chains
    for (int it = 0; it < 24; it++) begin
      nd = 1 + int'($urandom % 4);
      r = int'($urandom % 15);
      for (int i = 0; i < 4; i++) slot[i] = AW'((((r + i) % 15) + 1) * 16);
      for (int i = 0; i < nd; i++)
        set_desc(slot[i], (i == nd - 1) ? 8'h00 : slot[i + 1], AW'($urandom % 8),
                 AW'($urandom), AW'($urandom));
      clear_log();
      walk_chain(slot[0]);
      cfg_write(1'b1, slot[0]);
      wait_idle("R6");
      cmp_trace("R6 R4 random chain");
      chk(done_cnt == 1 && !done_wide, "R7", "random chain_done pulses", done_cnt, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule